// File: doc/BRIEF.md
# Memory Lane Alignment Unit

This block sits between a processor's register datapath and a 32-bit word-addressed memory. On a store it takes the register value, the low bits of the effective byte address and the access size. It returns the write data moved into the correct byte lanes, together with the byte enables. On a load it takes the fetched memory word. It picks out the addressed half word or byte and widens the result to 32 bits, with zero extension or sign extension.

The unit checks the alignment of each access. A word at an address that is not a multiple of four traps. A half word at an odd address traps. A byte never traps. On a trap the unit reports the fixed handler address 0x80000000 and suppresses the memory write.

Loaded results also carry zero and negative flags for the condition-code path. Each request is registered and answered exactly one cycle later.

Top module: `lane_align`

## Requirements
- R1: A word access (size code 2 or 3) whose address bits 1:0 are not 00 raises `rsp_trap`.
- R2: A half-word access (size code 1) whose address bit 0 is 1 raises `rsp_trap`; a half word at offset 0 or 2 does not trap.
- R3: A byte access (size code 0) never raises `rsp_trap`, at any offset.
- R4: `rsp_trap_vec` is 0x80000000 when `rsp_trap` is 1, and 0 otherwise.
- R5: Lanes are little-endian: address offset n holds bits 8n+7:8n, and a half word at offset 2 holds bits 31:16. A store places the size-masked register value in those lanes and zeroes the other bits of `rsp_wdata`. A word store passes the value through unchanged.
- R6: On a store that does not trap, the byte enables are 1111 for a word. For a half word they are 0011 at offset 0 and 1100 at offset 2. For a byte they are one-hot, with bit n set for offset n.
- R7: On a trap, and on any load, `rsp_be` and `rsp_wdata` are zero, so no memory write occurs.
- R8: A load that does not trap returns the addressed lanes: the full word for a word load, or the half word or byte moved down to bit 0. A half word or byte is zero-extended when `req_signed`=0 and sign-extended when `req_signed`=1. On a store or a trap, `rsp_load_data` is zero.
- R9: `rsp_z` is 1 exactly when `rsp_load_data` is zero, `rsp_n` equals `rsp_load_data[31]`, and `rsp_v` and `rsp_c` are always 0.
- R10: Every request with `req_valid`=1 produces exactly one response with `rsp_valid`=1 on the following clock edge.
- R11: While `rst_n` is low, `rsp_valid`, `rsp_trap`, `rsp_be` and `rsp_wdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 half word, 2 or 3 word |
| req_signed | input | 1 | Sign-extend load result |
| req_addr | input | 2 | Low bits of effective byte address |
| req_wdata | input | 32 | Register value to store |
| req_rdata | input | 32 | Word fetched from memory |
| rsp_valid | output | 1 | Response present |
| rsp_trap | output | 1 | Alignment trap |
| rsp_trap_vec | output | 32 | Trap target address |
| rsp_wdata | output | 32 | Lane-positioned store data |
| rsp_be | output | 4 | Store byte enables |
| rsp_load_data | output | 32 | Extended load result |
| rsp_z | output | 1 | Load result is zero |
| rsp_n | output | 1 | Load result is negative |
| rsp_v | output | 1 | Overflow flag, always 0 |
| rsp_c | output | 1 | Carry flag, always 0 |

## Verification
The unit is driven with every size at all four offsets, for both loads and stores. This separates the trap conditions for words, half words and bytes, and shows that each lane is chosen by its offset. The load words set a distinct value in every byte, and their top bits are set in some lanes and clear in others. That makes a wrong lane, a wrong extension kind or a wrong sign source show up as a distinct value. Store data with every byte nonzero shows whether masking to the access size was done. Zero-valued and negative loads exercise the flag outputs. A trapping store checks that no byte enable survives.

// File: rtl/lane_align.sv
module lane_align #(
  parameter logic [31:0] TRAP_VEC = 32'h8000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_store,
  input  logic [1:0]  req_size,
  input  logic        req_signed,
  input  logic [1:0]  req_addr,
  input  logic [31:0] req_wdata,
  input  logic [31:0] req_rdata,
  output logic        rsp_valid,
  output logic        rsp_trap,
  output logic [31:0] rsp_trap_vec,
  output logic [31:0] rsp_wdata,
  output logic [3:0]  rsp_be,
  output logic [31:0] rsp_load_data,
  output logic        rsp_z,
  output logic        rsp_n,
  output logic        rsp_v,
  output logic        rsp_c
);
  logic is_word, is_half, trap;
  logic [3:0]  be_c;
  logic [31:0] wd_c, sh_c, ld_c;

  assign is_word = req_size[1];
  assign is_half = (req_size == 2'b01);
  assign trap    = (is_word && req_addr != 2'b00) || (is_half && req_addr[0]);

  assign be_c = is_word ? 4'hF
              : is_half ? (req_addr[1] ? 4'hC : 4'h3)
              : (4'h1 << req_addr);

  assign wd_c = is_word ? req_wdata
              : is_half ? ({16'b0, req_wdata[15:0]} << {req_addr[1], 4'b0})
              : ({24'b0, req_wdata[7:0]} << {req_addr, 3'b0});

  assign sh_c = req_rdata >> {req_addr, 3'b0};
  assign ld_c = is_word ? req_rdata
              : is_half ? {{16{req_signed & sh_c[15]}}, sh_c[15:0]}
              : {{24{req_signed & sh_c[7]}}, sh_c[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_trap      <= 1'b0;
      rsp_be        <= 4'h0;
      rsp_wdata     <= 32'h0;
      rsp_load_data <= 32'h0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_trap      <= trap;
        rsp_be        <= (req_store && !trap) ? be_c : 4'h0;
        rsp_wdata     <= (req_store && !trap) ? wd_c : 32'h0;
        rsp_load_data <= (!req_store && !trap) ? ld_c : 32'h0;
      end
    end
  end

  assign rsp_trap_vec = rsp_trap ? TRAP_VEC : 32'h0;
  assign rsp_z = (rsp_load_data == 32'h0);
  assign rsp_n = rsp_load_data[31];
  assign rsp_v = 1'b0;
  assign rsp_c = 1'b0;
endmodule

module lane_align_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_store,
  input logic [1:0]  req_size,
  input logic [1:0]  req_addr,
  input logic        rsp_valid,
  input logic        rsp_trap,
  input logic [31:0] rsp_trap_vec,
  input logic [3:0]  rsp_be,
  input logic        rsp_v,
  input logic        rsp_c
);
  // R1
  word_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size[1] && req_addr != 2'b00 |=> rsp_trap);
  // R2
  half_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 2'b01 |=> rsp_trap == $past(req_addr[0]));
  // R3
  byte_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 2'b00 |=> !rsp_trap);
  // R4
  trap_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_trap |-> rsp_trap_vec == 32'h8000_0000);
  // R6
  byte_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_store && req_size == 2'b00 |=> $countones(rsp_be) == 1);
  // R7
  trap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_trap |-> rsp_be == 4'h0);
  // R9
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_v && !rsp_c);
  // R10
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
endmodule

bind lane_align lane_align_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
  .req_size(req_size), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_trap(rsp_trap), .rsp_trap_vec(rsp_trap_vec), .rsp_be(rsp_be),
  .rsp_v(rsp_v), .rsp_c(rsp_c)
);

// File: tb/lane_align_bench.sv
`timescale 1ns/1ps
module lane_align_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0;
  logic [1:0] req_size = 2'b0, req_addr = 2'b0;
  logic [31:0] req_wdata = 32'h0, req_rdata = 32'h0;
  logic rsp_valid, rsp_trap, rsp_z, rsp_n, rsp_v, rsp_c;
  logic [31:0] rsp_trap_vec, rsp_wdata, rsp_load_data;
  logic [3:0] rsp_be;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic        trap;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] ld;
    string       tag;
  } exp_t;
  exp_t q[$];

  lane_align u_lane_align (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input bit st, input logic [1:0] sz, input bit sg, input logic [1:0] a,
                      input logic [31:0] wd, input logic [31:0] rd, input string tag);
    exp_t e;
    int nbytes;
    int lane;
    nbytes = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    e.trap = (int'(a) % nbytes) != 0;
    e.be = 4'h0; e.wd = 32'h0; e.ld = 32'h0; e.tag = tag;
    if (!e.trap) begin
      for (int i = 0; i < nbytes; i++) begin
        lane = int'(a) + i;
        if (st) begin
          e.be[lane] = 1'b1;
          e.wd[lane*8 +: 8] = wd[i*8 +: 8];
        end else begin
          e.ld[i*8 +: 8] = rd[lane*8 +: 8];
        end
      end
      if (!st && sg && nbytes < 4 && e.ld[nbytes*8-1])
        for (int i = nbytes; i < 4; i++) e.ld[i*8 +: 8] = 8'hFF;
    end
    @(posedge clk); #1;
    req_valid = 1'b1; req_store = st; req_size = sz; req_signed = sg;
    req_addr = a; req_wdata = wd; req_rdata = rd;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t e;
      if (q.size() == 0) chk(1'b0, "R10", 32'h1, 32'h0);
      else begin
        e = q.pop_front();
        chk(rsp_trap == e.trap, e.tag, {31'b0, rsp_trap}, {31'b0, e.trap});
        chk(rsp_trap_vec == (e.trap ? 32'h8000_0000 : 32'h0), "R4", rsp_trap_vec, e.trap ? 32'h8000_0000 : 32'h0);
        chk(rsp_be == e.be, "R6/R7", {28'b0, rsp_be}, {28'b0, e.be});
        chk(rsp_wdata == e.wd, "R5", rsp_wdata, e.wd);
        chk(rsp_load_data == e.ld, "R8", rsp_load_data, e.ld);
        chk(rsp_z == (e.ld == 0) && rsp_n == e.ld[31] && !rsp_v && !rsp_c, "R9",
            {28'b0, rsp_z, rsp_n, rsp_v, rsp_c}, {28'b0, e.ld == 0, e.ld[31], 2'b00});
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11
    chk(rsp_valid == 0 && rsp_trap == 0 && rsp_be == 0 && rsp_wdata == 0, "R11",
        {rsp_valid, rsp_trap, rsp_be, rsp_wdata[25:0]}, 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;

    for (int a = 0; a < 4; a++) begin
      // R3 byte at every offset, both load kinds and store
      send(1'b1, 2'd0, 1'b0, 2'(a), 32'hA1B2C3D4, 32'h0, "R3");
      send(1'b0, 2'd0, 1'b0, 2'(a), 32'h0, 32'h807F_C33C, "R3");
      send(1'b0, 2'd0, 1'b1, 2'(a), 32'h0, 32'h807F_C33C, "R3");
      // R2 half word
      send(1'b1, 2'd1, 1'b0, 2'(a), 32'h1234_9876, 32'h0, "R2");
      send(1'b0, 2'd1, 1'b0, 2'(a), 32'h0, 32'h8001_7FFE, "R2");
      send(1'b0, 2'd1, 1'b1, 2'(a), 32'h0, 32'h8001_7FFE, "R2");
      // R1 word, both word codes
      send(1'b1, 2'd2, 1'b0, 2'(a), 32'hDEAD_BEEF, 32'h0, "R1");
      send(1'b0, 2'd3, 1'b1, 2'(a), 32'h0, 32'hF00D_CAFE, "R1");
    end
    // R9 zero and negative results
    send(1'b0, 2'd2, 1'b0, 2'd0, 32'h0, 32'h0, "R9");
    send(1'b0, 2'd0, 1'b1, 2'd1, 32'h0, 32'h0000_8000, "R9");
    send(1'b0, 2'd1, 1'b1, 2'd2, 32'h0, 32'hFFFF_0000, "R9");
    @(posedge clk); #1 req_valid = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10 every request answered once
    chk(q.size() == 0 && rsp_valid == 0, "R10", q.size(), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule